// File: doc/BRIEF.md
# Prioritized interrupt level resolver

The resolver turns the pending software and external interrupt requests of a core into one priority level plus a summary mask. The core invokes it at each instruction boundary. The resolver then decides whether that level beats the current processor priority level. If it does, the resolver fires a one-cycle trap strobe. In the same cycle it presents the summary mask and the level as write data for the interrupt-summary register and the interrupt-ID register.

Software request bits cover the index range `SW_LO` up to `SW_HI-1`. A set bit at index i stands for level `i - SW_LO + 1`. External request bits cover `EXT_LO` up to `EXT_HI-1`, and each stands for its own index as its level. Within a source, the highest set bit decides the level. If any external request is present, the external level replaces the software level.

An evaluation takes place only when all of these hold:
- the pending-check flag is set;
- bit 0 of the program counter is clear, so the core is not in privileged mode;
- the core is not resuming an instruction that was already fetched before a stall.

Every evaluation asks the owner of the flag to clear it.

Top module: `irq_resolver`

## Requirements
- R1: After reset, `trap_o`, `chk_clr_o`, `isr_o` and `intid_o` are all zero.
- R2: A software request bit i with `SW_LO <= i < SW_HI` resolves to level `i - SW_LO + 1` (default range 4..19, so bit 4 gives level 1 and bit 19 gives level 16).
- R3: When several software bits are set, the highest index sets the level.
- R4: An external request bit i with `EXT_LO <= i < EXT_HI` resolves to level i (default 20..30). When any such bit is set, the highest one sets the level, whatever the software requests are.
- R5: `isr_o` carries every set request bit inside its source's range, each at its own bit position. Request bits outside both ranges (default bits 0..3 and 31) appear in neither the level nor the mask.
- R6: A trap is raised only when the resolved level is nonzero and strictly greater than `cur_ipl_i`. An equal level raises no trap.
- R7: When `pc_i[0]` is 1, no evaluation takes place, so neither `trap_o` nor `chk_clr_o` pulses.
- R8: When `fetch_resume_i` is 1, no evaluation takes place.
- R9: When `chk_pend_i` is 0, no evaluation takes place.
- R10: Each evaluation pulses `chk_clr_o` in the cycle after the evaluating clock edge, whether or not a trap results. Each trap also pulses `trap_o` in that same cycle.
- R11: `isr_o` and `intid_o` take new values only in the cycle where `trap_o` is high, and otherwise keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_req_i | input | REQ_W | Software interrupt request register |
| ext_req_i | input | REQ_W | External interrupt status vector |
| cur_ipl_i | input | LVL_W | Current processor priority level |
| pc_i | input | PC_W | Program counter; bit 0 marks privileged mode |
| chk_pend_i | input | 1 | Pending-check flag |
| fetch_resume_i | input | 1 | Core is resuming an already-fetched instruction |
| trap_o | output | 1 | One-cycle interrupt trap strobe |
| isr_o | output | REQ_W | Summary mask write data |
| intid_o | output | LVL_W | Interrupt ID (level) write data |
| chk_clr_o | output | 1 | One-cycle request to clear the pending-check flag |

## Verification
The assertions assume that every input is stable and known at each rising edge while reset is released. They also compare `intid_o` against the `cur_ipl_i` sampled at the evaluating edge, which assumes the priority level is taken at that edge. The bench changes inputs only on falling edges and holds each stimulus for exactly one rising edge. It drops `chk_pend_i` before the next edge, so every strobe it checks comes from a single evaluation.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned LVL_W_DEF  = 5;
  localparam int unsigned REQ_W_DEF  = 32;
  localparam int unsigned PC_W_DEF   = 32;
  localparam int unsigned SW_LO_DEF  = 4;
  localparam int unsigned SW_HI_DEF  = 20;
  localparam int unsigned EXT_LO_DEF = 20;
  localparam int unsigned EXT_HI_DEF = 31;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SW   = 2'd1,
    SRC_EXT  = 2'd2
  } irq_src_e;
endpackage

// File: rtl/irq_scan.sv
// Ascending scan over [LO, HI): the last (highest) set bit sets the level.
module irq_scan #(
  parameter int unsigned REQ_W     = 32,
  parameter int unsigned LVL_W     = 5,
  parameter int unsigned LO        = 4,
  parameter int unsigned HI        = 20,
  parameter int unsigned LVL_AT_LO = 1
) (
  input  logic [REQ_W-1:0] req_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic [REQ_W-1:0] mask_o,
  output logic             any_o
);
  always_comb begin
    lvl_o  = '0;
    mask_o = '0;
    for (int i = LO; i < HI; i++) begin
      if (req_i[i]) begin
        lvl_o     = LVL_W'(LVL_AT_LO + i - LO);
        mask_o[i] = 1'b1;
      end
    end
  end

  assign any_o = |mask_o;
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned PC_W = 32
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            chk_pend_i,
  input  logic            fetch_resume_i,
  output logic            eval_o
);
  assign eval_o = chk_pend_i & ~pc_i[0] & ~fetch_resume_i;
endmodule

// File: rtl/irq_trap_reg.sv
module irq_trap_reg #(
  parameter int unsigned REQ_W = 32,
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eval_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [REQ_W-1:0] mask_i,
  input  logic [LVL_W-1:0] cur_ipl_i,
  output logic             trap_o,
  output logic [REQ_W-1:0] isr_o,
  output logic [LVL_W-1:0] intid_o,
  output logic             chk_clr_o
);
  logic win;
  assign win = eval_i && (lvl_i != '0) && (lvl_i > cur_ipl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o    <= 1'b0;
      chk_clr_o <= 1'b0;
      isr_o     <= '0;
      intid_o   <= '0;
    end else begin
      trap_o    <= win;
      chk_clr_o <= eval_i;
      if (win) begin
        isr_o   <= mask_i;
        intid_o <= lvl_i;
      end
    end
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
#(
  parameter int unsigned LVL_W  = LVL_W_DEF,
  parameter int unsigned REQ_W  = REQ_W_DEF,
  parameter int unsigned PC_W   = PC_W_DEF,
  parameter int unsigned SW_LO  = SW_LO_DEF,
  parameter int unsigned SW_HI  = SW_HI_DEF,
  parameter int unsigned EXT_LO = EXT_LO_DEF,
  parameter int unsigned EXT_HI = EXT_HI_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REQ_W-1:0] sw_req_i,
  input  logic [REQ_W-1:0] ext_req_i,
  input  logic [LVL_W-1:0] cur_ipl_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             chk_pend_i,
  input  logic             fetch_resume_i,
  output logic             trap_o,
  output logic [REQ_W-1:0] isr_o,
  output logic [LVL_W-1:0] intid_o,
  output logic             chk_clr_o
);
  localparam int unsigned NSRC = 2;

  logic [LVL_W-1:0] src_lvl  [NSRC];
  logic [REQ_W-1:0] src_mask [NSRC];
  logic [NSRC-1:0]  src_any;
  logic [REQ_W-1:0] src_req  [NSRC];

  assign src_req[0] = sw_req_i;
  assign src_req[1] = ext_req_i;

  // source 0 = software (level offset), source 1 = external (level = index)
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int unsigned LO  = (s == 0) ? SW_LO : EXT_LO;
    localparam int unsigned HI  = (s == 0) ? SW_HI : EXT_HI;
    localparam int unsigned LAT = (s == 0) ? 1     : EXT_LO;
    irq_scan #(
      .REQ_W(REQ_W), .LVL_W(LVL_W), .LO(LO), .HI(HI), .LVL_AT_LO(LAT)
    ) u_scan (
      .req_i (src_req[s]),
      .lvl_o (src_lvl[s]),
      .mask_o(src_mask[s]),
      .any_o (src_any[s])
    );
  end

  irq_src_e         win_src;
  logic [LVL_W-1:0] res_lvl;
  logic [REQ_W-1:0] res_mask;
  logic             eval;

  always_comb begin
    if (src_any[1])      win_src = SRC_EXT;
    else if (src_any[0]) win_src = SRC_SW;
    else                 win_src = SRC_NONE;
    case (win_src)
      SRC_EXT: res_lvl = src_lvl[1];
      SRC_SW:  res_lvl = src_lvl[0];
      default: res_lvl = '0;
    endcase
    res_mask = src_mask[0] | src_mask[1];
  end

  irq_gate #(.PC_W(PC_W)) u_gate (
    .pc_i          (pc_i),
    .chk_pend_i    (chk_pend_i),
    .fetch_resume_i(fetch_resume_i),
    .eval_o        (eval)
  );

  irq_trap_reg #(.REQ_W(REQ_W), .LVL_W(LVL_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .eval_i   (eval),
    .lvl_i    (res_lvl),
    .mask_i   (res_mask),
    .cur_ipl_i(cur_ipl_i),
    .trap_o   (trap_o),
    .isr_o    (isr_o),
    .intid_o  (intid_o),
    .chk_clr_o(chk_clr_o)
  );
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned REQ_W = 32,
  parameter int unsigned PC_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] cur_ipl_i,
  input logic [PC_W-1:0]  pc_i,
  input logic             chk_pend_i,
  input logic             fetch_resume_i,
  input logic             trap_o,
  input logic [REQ_W-1:0] isr_o,
  input logic [LVL_W-1:0] intid_o,
  input logic             chk_clr_o
);
  assert_priv_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_i[0] |=> !chk_clr_o && !trap_o);

  assert_resume_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_resume_i |=> !chk_clr_o && !trap_o);

  assert_no_pend_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_pend_i |=> !chk_clr_o && !trap_o);

  assert_eval_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_pend_i && !pc_i[0] && !fetch_resume_i) |=> chk_clr_o);

  assert_trap_with_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> chk_clr_o);

  assert_trap_beats_ipl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (intid_o != '0) && (intid_o > $past(cur_ipl_i)));

  assert_hold_no_trap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> $stable(isr_o) && $stable(intid_o));
endmodule

bind irq_resolver irq_resolver_chk #(
  .LVL_W(LVL_W), .REQ_W(REQ_W), .PC_W(PC_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cur_ipl_i     (cur_ipl_i),
  .pc_i          (pc_i),
  .chk_pend_i    (chk_pend_i),
  .fetch_resume_i(fetch_resume_i),
  .trap_o        (trap_o),
  .isr_o         (isr_o),
  .intid_o       (intid_o),
  .chk_clr_o     (chk_clr_o)
);

// File: tb/sim_irq_resolver.sv
`timescale 1ns/1ps
module sim_irq_resolver;
  localparam int LVL_W = 5;
  localparam int REQ_W = 32;
  localparam int PC_W  = 32;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [REQ_W-1:0] sw_req = '0;
  logic [REQ_W-1:0] ext_req = '0;
  logic [LVL_W-1:0] cur_ipl = '0;
  logic [PC_W-1:0]  pc = '0;
  logic             chk_pend = 1'b0;
  logic             fetch_resume = 1'b0;
  logic             trap;
  logic [REQ_W-1:0] isr;
  logic [LVL_W-1:0] intid;
  logic             chk_clr;

  int total = 0;
  int bad = 0;
  logic [REQ_W-1:0] exp_isr = '0;
  logic [LVL_W-1:0] exp_id = '0;

  always #2.5 clk = ~clk;

  irq_resolver u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sw_req_i(sw_req), .ext_req_i(ext_req),
    .cur_ipl_i(cur_ipl), .pc_i(pc), .chk_pend_i(chk_pend),
    .fetch_resume_i(fetch_resume), .trap_o(trap), .isr_o(isr),
    .intid_o(intid), .chk_clr_o(chk_clr)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Requirement-level model: sw bits 4..19 -> level i-3, ext bits 20..30 -> level i.
  task automatic apply(input string tag, input logic [REQ_W-1:0] sw, input logic [REQ_W-1:0] ext,
                       input logic [LVL_W-1:0] ipl, input logic [PC_W-1:0] p,
                       input logic pend, input logic res);
    int lvl = 0;
    logic [REQ_W-1:0] m = '0;
    logic ev, tr;
    for (int i = 4; i < 20; i++) if (sw[i]) begin lvl = i - 3; m[i] = 1'b1; end
    for (int i = 20; i < 31; i++) if (ext[i]) begin lvl = i; m[i] = 1'b1; end
    ev = pend && !p[0] && !res;
    tr = ev && (lvl != 0) && (lvl > int'(ipl));
    if (tr) begin exp_isr = m; exp_id = LVL_W'(lvl); end
    @(negedge clk);
    sw_req = sw; ext_req = ext; cur_ipl = ipl; pc = p; chk_pend = pend; fetch_resume = res;
    @(negedge clk);
    chk_pend = 1'b0;
    chk(tag, "trap", 64'(trap), 64'(tr));
    chk(tag, "clr", 64'(chk_clr), 64'(ev));
    chk(tag, "isr", 64'(isr), 64'(exp_isr));
    chk(tag, "intid", 64'(intid), 64'(exp_id));
  endtask

  task automatic t_reset;
    chk("R1", "trap", 64'(trap), 0);
    chk("R1", "clr", 64'(chk_clr), 0);
    chk("R1", "isr", 64'(isr), 0);
    chk("R1", "intid", 64'(intid), 0);
  endtask

  task automatic t_sw_map;
    apply("R2", 32'h0000_0010, '0, 5'd0, 32'h100, 1'b1, 1'b0);
    apply("R2", 32'h0008_0000, '0, 5'd0, 32'h100, 1'b1, 1'b0);
  endtask

  task automatic t_sw_prio;
    apply("R3", 32'h0000_4210, '0, 5'd2, 32'h104, 1'b1, 1'b0);
  endtask

  task automatic t_ext;
    apply("R4", 32'h0008_0010, 32'h0020_0000, 5'd3, 32'h108, 1'b1, 1'b0);
    apply("R4", 32'h0000_0000, 32'h4010_0000, 5'd3, 32'h108, 1'b1, 1'b0);
  endtask

  task automatic t_summary;
    apply("R5", 32'h0000_0F60, 32'h8000_000F, 5'd1, 32'h10c, 1'b1, 1'b0);
    apply("R5", 32'h0000_000F, 32'h8000_000F, 5'd0, 32'h10c, 1'b1, 1'b0);
  endtask

  task automatic t_ipl;
    apply("R6", 32'h0000_0100, '0, 5'd5, 32'h110, 1'b1, 1'b0);
    apply("R6", 32'h0000_0100, '0, 5'd4, 32'h110, 1'b1, 1'b0);
    apply("R6", '0, 32'h0080_0000, 5'd31, 32'h110, 1'b1, 1'b0);
  endtask

  task automatic t_priv;
    apply("R7", '0, 32'h4000_0000, 5'd0, 32'h201, 1'b1, 1'b0);
  endtask

  task automatic t_resume;
    apply("R8", '0, 32'h4000_0000, 5'd0, 32'h200, 1'b1, 1'b1);
  endtask

  task automatic t_nopend;
    apply("R9", '0, 32'h4000_0000, 5'd0, 32'h200, 1'b0, 1'b0);
  endtask

  task automatic t_clr_no_trap;
    apply("R10", '0, '0, 5'd0, 32'h200, 1'b1, 1'b0);
    apply("R10", 32'h0001_0000, '0, 5'd0, 32'h200, 1'b1, 1'b0);
    @(negedge clk);
    chk("R10", "trap pulse width", 64'(trap), 0);
    chk("R10", "clr pulse width", 64'(chk_clr), 0);
  endtask

  task automatic t_hold;
    apply("R11", 32'h0000_0020, '0, 5'd0, 32'h300, 1'b1, 1'b0);
    apply("R11", 32'h0000_0040, '0, 5'd9, 32'h300, 1'b1, 1'b0);
    apply("R11", 32'h0001_0000, 32'h0100_0000, 5'd0, 32'h301, 1'b1, 1'b0);
  endtask

  initial begin
    #1;
    t_reset;
    #20;
    @(negedge clk);
    rst_ni = 1'b1;
    t_reset;
    t_sw_map;
    t_sw_prio;
    t_ext;
    t_summary;
    t_ipl;
    t_priv;
    t_resume;
    t_nopend;
    t_clr_no_trap;
    t_hold;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule